// File: doc/BRIEF.md
# Back-channel CRC error recorder

This block watches frames arriving on a serial back channel and checks the CRC byte that closes each frame. Each failed check is counted in one of two 8-bit counters. The functional counter collects failures while the far end runs normally. The self-test counter collects failures only while the far end reports that it is in self-test (BIST) mode. The self-test counter clears itself when self-test starts, and it keeps its final count after self-test ends so that software can read the result of the last run.

Checking is gated by a link-detect input. No frame is looked at before the link is up. A frame that is open when the link drops is thrown away. Software can clear both counters with a single-cycle clear strobe. Both counters stop at their top value and do not wrap.

Frames arrive one byte per cycle when the valid input is high. Start and end markers frame the bytes. The expected CRC value is presented on its own input together with the last byte of the frame.

Top module: `bc_crc_recorder`

## Requirements
- R1: While `linkUp` is low, no byte is accepted, so a frame driven then leaves both counters unchanged.
- R2: The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0x00. It is computed MSB first over every byte of the frame, including the end byte. It is compared with `rxCrc` on the end beat, and any mismatch is an error. For example, the ASCII bytes "123456789" give 0xF4.
- R3: A byte is taken on a clock edge when `frmValid` is high. `frmStart` marks the first byte and `frmEnd` marks the last. Both markers on one beat form a one-byte frame. A non-start beat with no frame open is ignored.
- R4: An error on an end beat with `farBist` low adds one to `funcErrCnt`, visible after the clock edge that samples that beat.
- R5: An error on an end beat with `farBist` high adds one to `bistErrCnt` and leaves `funcErrCnt` unchanged.
- R6: While `farBist` is low, `bistErrCnt` holds its value, including the count left by the last self-test run.
- R7: A rising edge of `farBist` clears `bistErrCnt`. The clear wins over an error counted in the same cycle.
- R8: `swClear` high clears both counters. It wins over an error counted in the same cycle.
- R9: If `linkUp` drops while a frame is open, that frame is discarded, and a later end beat without a new start does not count.
- R10: Each counter saturates at 255.
- R11: After reset both counters read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Back-channel link detected |
| farBist | input | 1 | Far end reports self-test mode |
| frmValid | input | 1 | Frame byte valid this cycle |
| frmStart | input | 1 | First byte of a frame |
| frmEnd | input | 1 | Last byte of a frame |
| frmData | input | 8 | Frame byte |
| rxCrc | input | 8 | Received CRC byte, sampled on the end beat |
| swClear | input | 1 | Software clear of both counters |
| funcErrCnt | output | 8 | Functional-mode CRC error count |
| bistErrCnt | output | 8 | Self-test CRC error count of the current or last run |

## Verification
Two actions can land in the same cycle: the clear of the self-test counter on entry to self-test, and the increment caused by a failing frame end. The bench provokes this by raising `farBist` on the same beat as a one-byte frame with a wrong CRC, after a previous run has left a non-zero count. It judges the result by expecting `bistErrCnt` to read 0 and `funcErrCnt` to be unchanged. The software clear is tested the same way, driven together with a failing end beat.

// File: rtl/bc_crc_pkg.sv
package bc_crc_pkg;

  // Strobes from the frame/mode control to the CRC and counter datapath
  typedef struct packed {
    logic crcSeed;    // current byte opens a frame: start from the initial value
    logic crcStep;    // fold current byte into the running CRC
    logic checkNow;   // current byte closes a frame: compare with rxCrc
    logic routeBist;  // an error now belongs to the self-test counter
    logic clrFunc;    // clear the functional counter
    logic clrBist;    // clear the self-test counter
  } ctrl_strobe_t;

endpackage

// File: rtl/bc_crc_ctrl.sv
module bc_crc_ctrl
  import bc_crc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         linkUp,
  input  logic         farBist,
  input  logic         frmValid,
  input  logic         frmStart,
  input  logic         frmEnd,
  input  logic         swClear,
  output ctrl_strobe_t strb
);

  logic inFrame;
  logic bistPrev;
  logic beat;
  logic startBeat;
  logic contBeat;
  logic acceptBeat;
  logic bistRise;

  // Bytes only count once the link is detected
  assign beat       = frmValid & linkUp;
  assign startBeat  = beat & frmStart;
  assign contBeat   = beat & ~frmStart & inFrame;
  assign acceptBeat = startBeat | contBeat;
  assign bistRise   = farBist & ~bistPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      bistPrev <= 1'b0;
    end else begin
      bistPrev <= farBist;
      if (!linkUp) begin
        inFrame <= 1'b0;              // drop any open frame
      end else if (acceptBeat && frmEnd) begin
        inFrame <= 1'b0;
      end else if (startBeat) begin
        inFrame <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.crcSeed   = startBeat;
    strb.crcStep   = acceptBeat;
    strb.checkNow  = acceptBeat & frmEnd;
    strb.routeBist = farBist;
    strb.clrFunc   = swClear;
    strb.clrBist   = swClear | bistRise;
  end

endmodule

// File: rtl/bc_sat_counter.sv
module bc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;                      // clear wins over increment
    end else if (inc && (cnt != TOP)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bc_crc_datapath.sv
module bc_crc_datapath
  import bc_crc_pkg::*;
#(
  parameter int              BYTE_W = 8,
  parameter int              CRC_W  = 8,
  parameter int              CNT_W  = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h07,
  parameter logic [CRC_W-1:0] INIT  = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [BYTE_W-1:0] frmData,
  input  logic [CRC_W-1:0]  rxCrc,
  output logic [CNT_W-1:0]  funcErrCnt,
  output logic [CNT_W-1:0]  bistErrCnt
);

  localparam int NUM_CNT = 2;   // index 0: functional, 1: self-test

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcBase;
  logic [CRC_W-1:0] crcNext;
  logic             mismatch;
  logic             incVec [NUM_CNT];
  logic             clrVec [NUM_CNT];
  logic [CNT_W-1:0] cntVec [NUM_CNT];

  assign crcBase  = strb.crcSeed ? INIT : crcReg;
  assign crcNext  = crcByte(crcBase, frmData);
  assign mismatch = strb.checkNow && (crcNext != rxCrc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg <= INIT;
    end else if (strb.crcStep) begin
      crcReg <= crcNext;
    end
  end

  assign incVec[0] = mismatch & ~strb.routeBist;
  assign incVec[1] = mismatch &  strb.routeBist;
  assign clrVec[0] = strb.clrFunc;
  assign clrVec[1] = strb.clrBist;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    bc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (clrVec[g]),
      .inc  (incVec[g]),
      .cnt  (cntVec[g])
    );
  end

  assign funcErrCnt = cntVec[0];
  assign bistErrCnt = cntVec[1];

endmodule

// File: rtl/bc_crc_recorder.sv
module bc_crc_recorder
  import bc_crc_pkg::*;
#(
  parameter int              BYTE_W = 8,
  parameter int              CRC_W  = 8,
  parameter int              CNT_W  = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h07,
  parameter logic [CRC_W-1:0] INIT  = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              farBist,
  input  logic              frmValid,
  input  logic              frmStart,
  input  logic              frmEnd,
  input  logic [BYTE_W-1:0] frmData,
  input  logic [CRC_W-1:0]  rxCrc,
  input  logic              swClear,
  output logic [CNT_W-1:0]  funcErrCnt,
  output logic [CNT_W-1:0]  bistErrCnt
);

  ctrl_strobe_t strb;

  bc_crc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .linkUp   (linkUp),
    .farBist  (farBist),
    .frmValid (frmValid),
    .frmStart (frmStart),
    .frmEnd   (frmEnd),
    .swClear  (swClear),
    .strb     (strb)
  );

  bc_crc_datapath #(
    .BYTE_W (BYTE_W),
    .CRC_W  (CRC_W),
    .CNT_W  (CNT_W),
    .POLY   (POLY),
    .INIT   (INIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .frmData    (frmData),
    .rxCrc      (rxCrc),
    .funcErrCnt (funcErrCnt),
    .bistErrCnt (bistErrCnt)
  );

endmodule

// File: rtl/bc_crc_recorder_chk.sv
module bc_crc_recorder_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             linkUp,
  input logic             farBist,
  input logic             swClear,
  input logic [CNT_W-1:0] funcErrCnt,
  input logic [CNT_W-1:0] bistErrCnt
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R1: with the link down neither count can grow
  p_link_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    !linkUp |=> (funcErrCnt <= $past(funcErrCnt)) && (bistErrCnt <= $past(bistErrCnt)));

  // R4: the functional count grows by exactly one when it grows
  p_func_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (funcErrCnt > $past(funcErrCnt)) |-> (funcErrCnt == $past(funcErrCnt) + 1'b1));

  // R5: in self-test the functional count does not grow
  p_func_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    farBist |=> funcErrCnt <= $past(funcErrCnt));

  // R6: outside self-test the self-test count holds
  p_bist_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!farBist && !swClear) |=> bistErrCnt == $past(bistErrCnt));

  // R7: entering self-test leaves the self-test count at zero
  p_bist_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(farBist) |=> bistErrCnt == '0);

  // R8: software clear empties both counters
  p_sw_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    swClear |=> (funcErrCnt == '0) && (bistErrCnt == '0));

  // R10: a full functional counter stays full until cleared
  p_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (funcErrCnt == TOP && !swClear) |=> funcErrCnt == TOP);

endmodule

bind bc_crc_recorder bc_crc_recorder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .linkUp     (linkUp),
  .farBist    (farBist),
  .swClear    (swClear),
  .funcErrCnt (funcErrCnt),
  .bistErrCnt (bistErrCnt)
);

// File: tb/tb_bc_crc_recorder.sv
module tb_bc_crc_recorder;

  logic       clk = 1'b0;
  logic       rstN;
  logic       linkUp, farBist, frmValid, frmStart, frmEnd, swClear;
  logic [7:0] frmData, rxCrc;
  logic [7:0] funcErrCnt, bistErrCnt;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  bc_crc_recorder dut (
    .clk (clk), .rstN (rstN), .linkUp (linkUp), .farBist (farBist),
    .frmValid (frmValid), .frmStart (frmStart), .frmEnd (frmEnd),
    .frmData (frmData), .rxCrc (rxCrc), .swClear (swClear),
    .funcErrCnt (funcErrCnt), .bistErrCnt (bistErrCnt)
  );

  // Table entry: {bist, bad, len[2:0], seed[7:0], expFunc[7:0], expBist[7:0]}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd3, 8'h10, 8'd0, 8'd0},
    {1'b0, 1'b1, 3'd1, 8'h20, 8'd1, 8'd0},
    {1'b0, 1'b1, 3'd4, 8'h30, 8'd2, 8'd0},
    {1'b1, 1'b1, 3'd2, 8'h40, 8'd2, 8'd1},
    {1'b1, 1'b0, 3'd5, 8'h50, 8'd2, 8'd1},
    {1'b1, 1'b1, 3'd3, 8'h60, 8'd2, 8'd2},
    {1'b0, 1'b1, 3'd2, 8'h70, 8'd3, 8'd2},
    {1'b0, 1'b0, 3'd7, 8'h78, 8'd3, 8'd2},
    {1'b1, 1'b0, 3'd1, 8'h80, 8'd3, 8'd0},
    {1'b0, 1'b0, 3'd2, 8'h90, 8'd3, 8'd0}
  };

  // CRC-8, poly 0x07, init 0, MSB first (R2)
  function automatic logic [7:0] refCrc(input logic [7:0] seed, input int len);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < len; k++) begin
      logic [7:0] b = seed + 8'(k);
      for (int j = 7; j >= 0; j--) begin
        logic fb = c[7] ^ b[j];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    frmValid = 1'b0; frmStart = 1'b0; frmEnd = 1'b0; swClear = 1'b0;
    @(negedge clk);
  endtask

  // Drive a frame of len bytes seed, seed+1, ... with crcVal on the end beat
  task automatic sendRaw(input int len, input logic [7:0] seed, input logic [7:0] crcVal);
    for (int i = 0; i < len; i++) begin
      frmValid = 1'b1;
      frmStart = (i == 0);
      frmEnd   = (i == len - 1);
      frmData  = seed + 8'(i);
      rxCrc    = crcVal;
      @(negedge clk);
    end
    frmValid = 1'b0; frmStart = 1'b0; frmEnd = 1'b0; swClear = 1'b0;
  endtask

  task automatic sendFrame(input int len, input logic [7:0] seed, input bit bad);
    sendRaw(len, seed, refCrc(seed, len) ^ {7'd0, bad});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; linkUp = 1'b0; farBist = 1'b0; frmValid = 1'b0;
    frmStart = 1'b0; frmEnd = 1'b0; frmData = '0; rxCrc = '0; swClear = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 func after reset", funcErrCnt, 0);
    check("R11 bist after reset", bistErrCnt, 0);

    // Table walk: R3 R4 R5 R6 R7
    linkUp = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      farBist = v[28];
      idle();
      sendFrame(int'(v[26:24]), v[23:16], v[27]);
      check($sformatf("R4/R5 table %0d func", i), funcErrCnt, int'(v[15:8]));
      check($sformatf("R6/R7 table %0d bist", i), bistErrCnt, int'(v[7:0]));
    end

    // R2 known answer: "123456789" -> 0xF4
    sendRaw(9, 8'h31, 8'hF4);
    check("R2 good known answer", funcErrCnt, 3);
    sendRaw(9, 8'h31, 8'hF5);
    check("R2 bad known answer", funcErrCnt, 4);

    // R1 link down: bad frame ignored
    linkUp = 1'b0;
    idle();
    sendFrame(2, 8'hA0, 1'b1);
    check("R1 link down", funcErrCnt, 4);

    // R9 and R3: link drop mid-frame, orphan end beat ignored
    linkUp = 1'b1;
    idle();
    frmValid = 1'b1; frmStart = 1'b1; frmData = 8'hB0; @(negedge clk);
    frmStart = 1'b0; frmData = 8'hB1; @(negedge clk);
    frmValid = 1'b0; linkUp = 1'b0; @(negedge clk);
    linkUp = 1'b1; @(negedge clk);
    frmValid = 1'b1; frmEnd = 1'b1; frmData = 8'hB2; rxCrc = 8'h5A; @(negedge clk);
    idle();
    check("R9 discarded frame", funcErrCnt, 4);

    // R5 then R6: self-test run leaves count 2, held after exit
    farBist = 1'b1;
    idle();
    sendFrame(1, 8'hC0, 1'b1);
    sendFrame(3, 8'hC4, 1'b1);
    check("R5 bist count", bistErrCnt, 2);
    check("R5 func unchanged", funcErrCnt, 4);
    farBist = 1'b0;
    idle();
    sendFrame(2, 8'hD0, 1'b1);
    check("R6 bist held", bistErrCnt, 2);
    check("R4 func after exit", funcErrCnt, 5);

    // R7: entry edge together with a failing end beat
    farBist = 1'b1;
    sendFrame(1, 8'hE0, 1'b1);
    check("R7 clear beats increment", bistErrCnt, 0);
    check("R7 func unchanged", funcErrCnt, 5);

    // R10 saturation
    farBist = 1'b0;
    idle();
    for (int n = 0; n < 300; n++) sendFrame(1, 8'(n), 1'b1);
    check("R10 func saturates", funcErrCnt, 255);

    // R8: software clear together with a failing end beat
    farBist = 1'b1;
    idle();
    sendFrame(1, 8'hF0, 1'b1);
    check("R8 setup bist", bistErrCnt, 1);
    swClear = 1'b1;
    sendFrame(1, 8'hF1, 1'b1);
    check("R8 bist cleared", bistErrCnt, 0);
    check("R8 func cleared", funcErrCnt, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule